// File: doc/BRIEF.md
# Strobe-Handshake Slave Register Interface

This block connects a host processor to a bank of sixteen 16-bit registers over a synchronous, strobe-paced parallel bus. The host presents an address, asserts the select and address strobe lines, sets the direction line, and pulls one or both byte data strobes low. The block sees the strobe on a rising clock edge and steps through five fixed internal states. Data moves on the falling clock edge inside the third state. The cycle lasts until the host lets the data strobes go high again. The acknowledge output is high while the block is idle. It goes low for the length of a transfer and returns high in the state after the host has released the strobes.

The five states are:

- T1 `ST_T1_IDLE`: waiting for a cycle.
- T2 `ST_T2_DECODE`: the cycle has been seen and the address has been captured.
- T3 `ST_T3_MOVE`: the falling-edge data movement takes place.
- T4 `ST_T4_HOLD`: the block holds until both strobes are high.
- T5 `ST_T5_END`: the acknowledge output goes high again and the bus is released.

The transitions are:

- start (T1→T2)
- advance (T2→T3)
- moved (T3→T4)
- release (T4→T5)
- stretch (T4→T4)
- retire (T5→T1)

The block has no tri-state pad of its own. The pad is built outside from `data_out` and its enable `data_oe`.

Top module: `strobe_reg_slave`

## Requirements
- R1: After a synchronous reset (`rst` high on a rising edge), `ack_o` is 1, `data_oe` is 0 and every register reads back as 0.
- R2: A cycle starts only on a rising edge where `sel_n`=0, `addr_stb_n`=0 and at least one of `hi_stb_n` and `lo_stb_n` is 0. When a cycle starts, `ack_o` goes to 0 after that edge.
- R3: In a read cycle (`rd_wr`=1), `data_oe` rises at the falling edge in T3. At that point `data_out` carries the addressed register.
- R4: In a read, `data_oe` stays 1 and `data_out` stays unchanged for as long as the host keeps a strobe low.
- R5: The first rising edge in T4 that sees both strobes high ends the cycle. After that edge, `ack_o` is 1 and `data_oe` is 0.
- R6: In a write, `hi_stb_n`=0 selects data bits 15:8 and `lo_stb_n`=0 selects bits 7:0. A byte lane whose strobe is high keeps its old value.
- R7: Write data is taken from `data_in` at the falling edge in T3. Later changes to `data_in` have no effect.
- R8: No new cycle starts until both strobes have been sampled high, including after reset.
- R9: Strobes are ignored while `sel_n` or `addr_stb_n` is 1. In that case `ack_o` stays 1 and no register changes.
- R10: The address is captured when the cycle starts. Changing `bus_addr` later in the cycle does not redirect the access.
- R11: `ack_o` is 0 from T2 through T4, and `data_oe` is never 1 during a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register address |
| addr_stb_n | input | 1 | Address strobe, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| hi_stb_n | input | 1 | Upper byte data strobe, active low |
| lo_stb_n | input | 1 | Lower byte data strobe, active low |
| data_in | input | 16 | Write data from the host |
| data_out | output | 16 | Read data to the host |
| data_oe | output | 1 | Output enable for the external data pad |
| ack_o | output | 1 | Acknowledge: high when idle or finished, low during a cycle |

## Verification
The assertions check four behaviours on every cycle:

- the reset state of the acknowledge and enable outputs;
- that a falling acknowledge is always preceded by a valid start condition;
- that driven read data never changes while it is enabled;
- that the enable is never on while the acknowledge is high, and that a strobe release in T4 always retires the cycle.

Some behaviours only the bench scenarios can show. These are:

- that the correct register contents appear;
- byte-lane merging;
- that late write data and late address changes are ignored;
- the re-arming rule after reset;
- that unselected strobes leave the bank untouched, which the bench shows by reading registers back.

// File: rtl/strb_pkg.sv
package strb_pkg;

    // Local bus phase numbering T1..T5 of the slave
    typedef enum logic [2:0] {
        ST_T1_IDLE   = 3'd0,
        ST_T2_DECODE = 3'd1,
        ST_T3_MOVE   = 3'd2,
        ST_T4_HOLD   = 3'd3,
        ST_T5_END    = 3'd4
    } strb_state_e;

    // Two byte lanes: index 1 = upper strobe, index 0 = lower strobe
    localparam int LANES = 2;

endpackage

// File: rtl/strb_seq.sv
module strb_seq
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              addr_stb_n,
    input  logic              rd_wr,
    input  logic              hi_stb_n,
    input  logic              lo_stb_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output strb_state_e       state,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_read,
    output logic [LANES-1:0]  cyc_lanes,
    output logic              move_phase,
    output logic              wr_commit,
    output logic              drive_window,
    output logic              ack_o
);

    strb_state_e state_q, state_d;
    logic        armed_q;
    logic        both_high;
    logic        start;

    assign both_high = hi_stb_n && lo_stb_n;
    assign start     = (state_q == ST_T1_IDLE) && armed_q && !sel_n && !addr_stb_n
                       && !both_high;

    // next-state selection: start, advance, moved, release/stretch, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_T1_IDLE:   if (start) state_d = ST_T2_DECODE;
            ST_T2_DECODE: state_d = ST_T3_MOVE;
            ST_T3_MOVE:   state_d = ST_T4_HOLD;
            ST_T4_HOLD:   if (both_high) state_d = ST_T5_END;
            ST_T5_END:    state_d = ST_T1_IDLE;
            default:      state_d = ST_T1_IDLE;
        endcase
    end

    // state register plus per-cycle capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_T1_IDLE;
            armed_q   <= 1'b0;
            cyc_addr  <= '0;
            cyc_read  <= 1'b1;
            cyc_lanes <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                armed_q   <= 1'b0;
                cyc_addr  <= bus_addr;
                cyc_read  <= rd_wr;
                cyc_lanes <= {!hi_stb_n, !lo_stb_n};
            end else if (both_high) begin
                armed_q <= 1'b1;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        ack_o        = 1'b0;
        move_phase   = 1'b0;
        wr_commit    = 1'b0;
        drive_window = 1'b0;
        unique case (state_q)
            ST_T1_IDLE:   ack_o = 1'b1;
            ST_T2_DECODE: ack_o = 1'b0;
            ST_T3_MOVE: begin
                move_phase   = 1'b1;
                wr_commit    = !cyc_read;
                drive_window = cyc_read;
            end
            ST_T4_HOLD:   drive_window = cyc_read;
            ST_T5_END:    ack_o = 1'b1;
            default:      ack_o = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/strb_lane_io.sv
module strb_lane_io #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              move_phase,
    input  logic              drive_window,
    input  logic              cyc_read,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_hold,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    logic [DATA_W-1:0] rd_hold;
    logic              rd_vld;

    // falling-edge data movement inside T3
    always_ff @(negedge clk) begin
        if (rst) begin
            wr_hold <= '0;
            rd_hold <= '0;
            rd_vld  <= 1'b0;
        end else if (move_phase) begin
            wr_hold <= data_in;
            rd_hold <= rd_data;
            rd_vld  <= cyc_read;
        end else if (!drive_window) begin
            rd_vld <= 1'b0;
        end
    end

    // enable drops at once when the sequencer leaves T4
    assign data_oe  = rd_vld && drive_window;
    assign data_out = data_oe ? rd_hold : '0;

endmodule

// File: rtl/strb_regbank.sv
module strb_regbank
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int LANE_W   = DATA_W / LANES;

    logic [NUM_REGS*DATA_W-1:0] bank_flat;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(r)) && wr_lanes[l])
                    q <= wr_data[l*LANE_W +: LANE_W];
            end
            assign bank_flat[r*DATA_W + l*LANE_W +: LANE_W] = q;
        end
    end

    assign rd_data = bank_flat[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
    import strb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              addr_stb_n,
    input  logic              sel_n,
    input  logic              rd_wr,
    input  logic              hi_stb_n,
    input  logic              lo_stb_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ack_o
);

    strb_state_e       state_w;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_read;
    logic [LANES-1:0]  cyc_lanes;
    logic              move_phase;
    logic              wr_commit;
    logic              drive_window;
    logic [DATA_W-1:0] wr_hold;
    logic [DATA_W-1:0] rd_data;

    strb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .sel_n        (sel_n),
        .addr_stb_n   (addr_stb_n),
        .rd_wr        (rd_wr),
        .hi_stb_n     (hi_stb_n),
        .lo_stb_n     (lo_stb_n),
        .bus_addr     (bus_addr),
        .state        (state_w),
        .cyc_addr     (cyc_addr),
        .cyc_read     (cyc_read),
        .cyc_lanes    (cyc_lanes),
        .move_phase   (move_phase),
        .wr_commit    (wr_commit),
        .drive_window (drive_window),
        .ack_o        (ack_o)
    );

    strb_lane_io #(.DATA_W(DATA_W)) u_io (
        .clk          (clk),
        .rst          (rst),
        .move_phase   (move_phase),
        .drive_window (drive_window),
        .cyc_read     (cyc_read),
        .data_in      (data_in),
        .rd_data      (rd_data),
        .wr_hold      (wr_hold),
        .data_out     (data_out),
        .data_oe      (data_oe)
    );

    strb_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_commit),
        .wr_addr  (cyc_addr),
        .wr_lanes (cyc_lanes),
        .wr_data  (wr_hold),
        .rd_addr  (cyc_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/strobe_reg_slave_chk.sv
module strobe_reg_slave_chk #(
    parameter int DATA_W = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_n,
    input logic                 addr_stb_n,
    input logic                 hi_stb_n,
    input logic                 lo_stb_n,
    input logic [DATA_W-1:0]    data_out,
    input logic                 data_oe,
    input logic                 ack_o,
    input strb_pkg::strb_state_e st
);

    // R1: reset leaves the bus idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (ack_o && !data_oe));

    // R2: acknowledge only falls after a valid start condition
    a_r2_valid_start: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_o) |-> $past(!sel_n && !addr_stb_n && !(hi_stb_n && lo_stb_n)));

    // R4: driven data is steady while enabled
    a_r4_steady_data: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    // R5: release in T4 retires the cycle
    a_r5_release_ends: assert property (@(posedge clk) disable iff (rst)
        (st == strb_pkg::ST_T4_HOLD && hi_stb_n && lo_stb_n) |=> (ack_o && !data_oe));

    // R11: bus is only driven while a cycle is in progress
    a_r11_drive_in_cycle: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !ack_o);

endmodule

bind strobe_reg_slave strobe_reg_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (sel_n),
    .addr_stb_n (addr_stb_n),
    .hi_stb_n   (hi_stb_n),
    .lo_stb_n   (lo_stb_n),
    .data_out   (data_out),
    .data_oe    (data_oe),
    .ack_o      (ack_o),
    .st         (state_w)
);

// File: tb/strobe_reg_slave_test.sv
`timescale 1ns/1ps
module strobe_reg_slave_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        addr_stb_n, sel_n, rd_wr, hi_stb_n, lo_stb_n;
    logic [15:0] data_in;
    logic [15:0] data_out;
    logic        data_oe, ack_o;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] exp_q[$];
    logic [15:0] mdl[16];

    always #2.5 clk = ~clk;

    strobe_reg_slave uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .addr_stb_n(addr_stb_n),
        .sel_n(sel_n), .rd_wr(rd_wr), .hi_stb_n(hi_stb_n), .lo_stb_n(lo_stb_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ack_o(ack_o)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every read data phase pops one expected word (R3)
    initial begin
        forever begin
            @(posedge data_oe);
            #1;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected drive", data_out, 16'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk(data_out === e, "R3 read data", data_out, e);
            end
        end
    end

    task automatic bus_idle();
        sel_n = 1'b1; addr_stb_n = 1'b1; hi_stb_n = 1'b1; lo_stb_n = 1'b1;
        rd_wr = 1'b1;
    endtask

    task automatic do_read(input logic [3:0] a, input int stretch);
        @(posedge clk); #1;
        exp_q.push_back(mdl[a]);
        bus_addr = a; rd_wr = 1'b1; sel_n = 1'b0; addr_stb_n = 1'b0;
        hi_stb_n = 1'b0; lo_stb_n = 1'b0;
        repeat (3 + stretch) @(posedge clk);
        #1;
        chk(data_oe === 1'b1, "R4 enable held", {15'd0, data_oe}, 16'd1);
        chk(ack_o === 1'b0, "R11 ack low in cycle", {15'd0, ack_o}, 16'd0);
        hi_stb_n = 1'b1; lo_stb_n = 1'b1;
        @(posedge clk); #1;
        chk(ack_o === 1'b1 && data_oe === 1'b0, "R5 read end",
            {14'd0, ack_o, data_oe}, 16'd2);
        sel_n = 1'b1; addr_stb_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d,
                            input bit use_hi, input bit use_lo,
                            input bit late_data, input bit move_addr);
        @(posedge clk); #1;
        bus_addr = a; rd_wr = 1'b0; data_in = d; sel_n = 1'b0; addr_stb_n = 1'b0;
        hi_stb_n = !use_hi; lo_stb_n = !use_lo;
        @(posedge clk); #1;
        chk(ack_o === 1'b0, "R2 ack falls", {15'd0, ack_o}, 16'd0);
        if (move_addr) bus_addr = a ^ 4'hF;
        @(posedge clk); #3.5;
        if (late_data) data_in = ~d;
        @(posedge clk); #1;
        chk(data_oe === 1'b0, "R11 no drive on write", {15'd0, data_oe}, 16'd0);
        hi_stb_n = 1'b1; lo_stb_n = 1'b1;
        @(posedge clk); #1;
        chk(ack_o === 1'b1, "R5 write end", {15'd0, ack_o}, 16'd1);
        sel_n = 1'b1; addr_stb_n = 1'b1; rd_wr = 1'b1;
        @(posedge clk);
        if (use_hi) mdl[a][15:8] = d[15:8];
        if (use_lo) mdl[a][7:0] = d[7:0];
    endtask

    task automatic stray_strobes(input logic sel_v, input logic as_v);
        @(posedge clk); #1;
        sel_n = sel_v; addr_stb_n = as_v; rd_wr = 1'b0; bus_addr = 4'd3;
        data_in = 16'hFFFF;
        for (int k = 0; k < 3; k++) begin
            hi_stb_n = 1'b0; lo_stb_n = 1'b0;
            @(posedge clk); #1;
            chk(ack_o === 1'b1, "R9 unselected strobe", {15'd0, ack_o}, 16'd1);
            hi_stb_n = 1'b1; lo_stb_n = 1'b1;
            @(posedge clk); #1;
        end
        bus_idle();
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0;
        bus_idle();
        bus_addr = 4'd0; data_in = 16'h0;
        rst = 1'b1;
        // strobes held low through reset: must not start a cycle afterwards
        sel_n = 1'b0; addr_stb_n = 1'b0; hi_stb_n = 1'b0; lo_stb_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(ack_o === 1'b1 && data_oe === 1'b0, "R1 reset outputs",
            {14'd0, ack_o, data_oe}, 16'd2);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(ack_o === 1'b1, "R8 not rearmed", {15'd0, ack_o}, 16'd1);
        end
        bus_idle();
        @(posedge clk);

        // R1: every register reads zero
        for (int i = 0; i < 16; i++) do_read(4'(i), 0);

        do_write(4'd3, 16'hA5C3, 1, 1, 0, 0);
        do_read(4'd3, 0);

        // R6: single-lane writes
        do_write(4'd5, 16'h1234, 1, 0, 0, 0);
        do_write(4'd6, 16'hBEEF, 0, 1, 0, 0);
        do_write(4'd5, 16'h7799, 0, 1, 0, 0);
        do_read(4'd5, 0);
        do_read(4'd6, 0);

        // R7: data changed after the T3 falling edge is ignored
        do_write(4'd7, 16'h0F0F, 1, 1, 1, 0);
        do_read(4'd7, 0);

        // R10: address moved after start is ignored
        do_write(4'd9, 16'h5A5A, 1, 1, 0, 1);
        do_read(4'd9, 0);
        do_read(4'd6, 0);

        // R4: stretched read
        do_read(4'd3, 6);

        // R9: strobes without select or address strobe
        stray_strobes(1'b1, 1'b0);
        stray_strobes(1'b0, 1'b1);
        @(posedge clk);
        do_read(4'd3, 0);

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R3 all reads seen", 16'(exp_q.size()), 16'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule